// File: doc/BRIEF.md
# Serial Memory Command Engine

This block is the slave-side protocol engine of a byte-addressed nonvolatile memory reached over a four-wire serial bus. It runs in the system clock domain. Its bus inputs (serial clock, active-low select, data in, active-low pause) arrive already synchronized. It detects serial clock edges by comparing each input with its registered copy, takes in an 8-bit command most significant bit first, and decodes six commands: array read, array write, latch write permission, drop write permission, status read and status write. Array commands are followed by a 16-bit address, of which only the low 13 bits are used.

On a read the engine presents an address to an external 8192-byte array model. It shifts each byte out on serial clock falling edges and advances the pointer after every byte, wrapping over the whole array. On a write it hands each completed byte, with its address, to a separate commit unit. It signals the commit when select rises on a byte boundary. The engine also holds the write-permission latch, builds the status byte, and freezes completely while the pause input is low.

Top module: `spi_mem_slave`

## Requirements
- R1: With `cs_n` low and `hold_n` high, `si` is sampled on each `sck` rising edge, the first after `cs_n` falls starting a command byte sent most significant bit first; 0x03 is array read, 0x02 array write, 0x06 latch write permission, 0x04 drop write permission, 0x05 status read, 0x01 status write.
- R2: Read and write commands take a 16-bit address, most significant bit first; the top three bits are ignored, so 0xE005 addresses byte 0x0005.
- R3: Read data leaves on `so` most significant bit first, changing only after `sck` falling edges; the pointer advances after every 8 bits and wraps from 0x1FFF to 0x0000 while `cs_n` stays low.
- R4: The write-permission latch is set only when `cs_n` rises after exactly eight bits of 0x06; any further `sck` rise before `cs_n` rises cancels it.
- R5: The latch is cleared when `cs_n` rises after exactly eight bits of 0x04, and also by a one-cycle `wr_done` pulse from the commit unit.
- R6: An array write or status write issued while the latch is clear produces no `wr_byte_valid`, `wr_commit` or `sr_wr_valid` pulse.
- R7: During an accepted write, each completed data byte gives a one-cycle `wr_byte_valid` with `wr_byte_addr` and `wr_byte_data`; the address advances only in its low 5 bits, so 0x003F is followed by 0x0020.
- R8: `wr_commit` pulses for one cycle after `cs_n` rises only if at least one data byte was completed and no partial byte is pending.
- R9: The status byte has bit 0 = `busy`, bit 1 = write-permission latch, bits 7:2 = `stat_hi`; it repeats for as long as clocks continue and is served while `busy` is high.
- R10: While `busy` is high an array read is refused: `so_oe` stays low for the whole transaction.
- R11: While `hold_n` is low, `sck` edges are ignored and all state holds; on release the transfer resumes at the paused bit.
- R12: An unknown command byte leaves the engine idle until `cs_n` rises; a rise of `cs_n` at any bit resets the bit count and command state.
- R13: An accepted status write passes the 8-bit byte that follows the command on `sr_wr_data` with a one-cycle `sr_wr_valid` after `cs_n` rises, provided exactly eight data bits were sent.
- R14: `so_oe` is low whenever `cs_n` is high or `hold_n` is low, and is high otherwise only while read data or status is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Synchronized serial clock |
| cs_n | input | 1 | Synchronized select, active low |
| si | input | 1 | Synchronized serial data in |
| hold_n | input | 1 | Synchronized pause, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| mem_addr | output | 13 | Array read address |
| mem_rdata | input | 8 | Array read data for `mem_addr`, same cycle |
| busy | input | 1 | Internal write cycle in progress |
| wr_done | input | 1 | Write cycle finished, clears the latch |
| stat_hi | input | 6 | Upper status bits held by the commit unit |
| wr_byte_valid | output | 1 | One data byte accepted |
| wr_byte_addr | output | 13 | Address of the accepted byte |
| wr_byte_data | output | 8 | Value of the accepted byte |
| wr_commit | output | 1 | Write sequence ended validly |
| sr_wr_valid | output | 1 | Status write accepted |
| sr_wr_data | output | 8 | Status write value |

## Verification
A serial clock rise is seen at the first system clock edge after the input changes, and it updates the shift and counter registers at that edge. A falling edge likewise updates `so` one cycle after the input falls. The bench therefore holds each bus level for several system cycles and reads `so` just before raising `sck`, a point half a serial period after the output changed. Strobes raised by a rise of `cs_n` last exactly one cycle, one cycle after the rise. A monitor counts them on falling system clock edges. Each check reads those counters only after the select has been high for several cycles, and the enable rule is compared on every cycle.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int BYTE_W     = 8;
    localparam int BIT_CNT_W  = 4;
    localparam int CMD_ADDR_W = 16;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;

    typedef enum logic [3:0] {
        ST_OP,
        ST_ADDR,
        ST_RD,
        ST_WDATA,
        ST_SRRD,
        ST_SRWR,
        ST_SRWR_DONE,
        ST_WREN,
        ST_WRDI,
        ST_IGNORE
    } eng_state_e;

    typedef struct packed {
        eng_state_e nxt;
        logic       is_rd;
    } dec_t;

    function automatic dec_t decode_op(logic [7:0] op, logic wel, logic busy);
        dec_t d;
        d.nxt   = ST_IGNORE;
        d.is_rd = 1'b0;
        case (op)
            OP_READ:  begin
                if (!busy) begin
                    d.nxt   = ST_ADDR;
                    d.is_rd = 1'b1;
                end
            end
            OP_WRITE: if (wel) d.nxt = ST_ADDR;
            OP_WREN:  d.nxt = ST_WREN;
            OP_WRDI:  d.nxt = ST_WRDI;
            OP_RDSR:  d.nxt = ST_SRRD;
            OP_WRSR:  if (wel) d.nxt = ST_SRWR;
            default:  d.nxt = ST_IGNORE;
        endcase
        return d;
    endfunction

    function automatic logic is_out_state(eng_state_e s);
        return (s == ST_RD) || (s == ST_SRRD);
    endfunction

endpackage

// File: rtl/spi_mem_edges.sv
module spi_mem_edges (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_q;
    logic cs_q;
    logic active;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    assign active   = !cs_n && hold_n;
    assign sck_rise = active && sck && !sck_q;
    assign sck_fall = active && !sck && sck_q;
    assign cs_rise  = cs_n && !cs_q;
endmodule

// File: rtl/spi_mem_cmd.sv
module spi_mem_cmd
    import spi_mem_pkg::*;
#(
    parameter int AW     = 13,
    parameter int PAGE_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                si,
    input  logic                sck_rise,
    input  logic                cs_rise,
    input  logic                busy,
    input  logic                wr_done,
    output eng_state_e          state,
    output logic [BIT_CNT_W-1:0] cnt,
    output logic                wel,
    output logic [AW-1:0]       ptr,
    output logic                wr_byte_valid,
    output logic [AW-1:0]       wr_byte_addr,
    output logic [BYTE_W-1:0]   wr_byte_data,
    output logic                wr_commit,
    output logic                sr_wr_valid,
    output logic [BYTE_W-1:0]   sr_wr_data
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT  = BIT_CNT_W'(BYTE_W - 1);
    localparam logic [BIT_CNT_W-1:0] LAST_ADDR = BIT_CNT_W'(CMD_ADDR_W - 1);

    logic [BYTE_W-2:0] sh;
    logic [AW-1:0]     ash;
    logic              is_rd;
    logic              wrote;
    logic [BYTE_W-1:0] byte_in;
    dec_t              dec;

    assign byte_in = {sh, si};
    assign dec     = decode_op(byte_in, wel, busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_OP;
            cnt           <= '0;
            wel           <= 1'b0;
            ptr           <= '0;
            sh            <= '0;
            ash           <= '0;
            is_rd         <= 1'b0;
            wrote         <= 1'b0;
            wr_byte_valid <= 1'b0;
            wr_byte_addr  <= '0;
            wr_byte_data  <= '0;
            wr_commit     <= 1'b0;
            sr_wr_valid   <= 1'b0;
            sr_wr_data    <= '0;
        end else begin
            wr_byte_valid <= 1'b0;
            wr_commit     <= 1'b0;
            sr_wr_valid   <= 1'b0;
            if (wr_done) wel <= 1'b0;
            if (cs_n) begin
                if (cs_rise) begin
                    case (state)
                        ST_WREN:      wel <= 1'b1;
                        ST_WRDI:      wel <= 1'b0;
                        ST_WDATA:     if (wrote && cnt == '0) wr_commit <= 1'b1;
                        ST_SRWR_DONE: sr_wr_valid <= 1'b1;
                        default:      ;
                    endcase
                end
                state <= ST_OP;
                cnt   <= '0;
                is_rd <= 1'b0;
                wrote <= 1'b0;
            end else if (sck_rise) begin
                case (state)
                    ST_OP: begin
                        sh <= byte_in[BYTE_W-2:0];
                        if (cnt == LAST_BIT) begin
                            cnt   <= '0;
                            state <= dec.nxt;
                            is_rd <= dec.is_rd;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        ash <= {ash[AW-2:0], si};
                        if (cnt == LAST_ADDR) begin
                            cnt   <= '0;
                            ptr   <= {ash[AW-2:0], si};
                            state <= is_rd ? ST_RD : ST_WDATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_RD, ST_SRRD: begin
                        if (cnt == LAST_BIT) begin
                            cnt <= '0;
                            if (state == ST_RD) ptr <= ptr + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_WDATA: begin
                        sh <= byte_in[BYTE_W-2:0];
                        if (cnt == LAST_BIT) begin
                            cnt           <= '0;
                            wrote         <= 1'b1;
                            wr_byte_valid <= 1'b1;
                            wr_byte_addr  <= ptr;
                            wr_byte_data  <= byte_in;
                            ptr <= {ptr[AW-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_SRWR: begin
                        sh <= byte_in[BYTE_W-2:0];
                        if (cnt == LAST_BIT) begin
                            cnt        <= '0;
                            sr_wr_data <= byte_in;
                            state      <= ST_SRWR_DONE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_WREN, ST_WRDI, ST_SRWR_DONE: state <= ST_IGNORE;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_mem_shifter.sv
module spi_mem_shifter
    import spi_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_fall,
    input  logic              out_phase,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              so
);
    logic [BYTE_W-2:0] rest;

    always_ff @(posedge clk) begin
        if (rst) begin
            so   <= 1'b0;
            rest <= '0;
        end else if (sck_fall && out_phase) begin
            if (load) begin
                so   <= load_byte[BYTE_W-1];
                rest <= load_byte[BYTE_W-2:0];
            end else begin
                so   <= rest[BYTE_W-2];
                rest <= {rest[BYTE_W-3:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int AW     = 13,
    parameter int PAGE_W = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck,
    input  logic                 cs_n,
    input  logic                 si,
    input  logic                 hold_n,
    output logic                 so,
    output logic                 so_oe,
    output logic [AW-1:0]        mem_addr,
    input  logic [BYTE_W-1:0]    mem_rdata,
    input  logic                 busy,
    input  logic                 wr_done,
    input  logic [BYTE_W-3:0]    stat_hi,
    output logic                 wr_byte_valid,
    output logic [AW-1:0]        wr_byte_addr,
    output logic [BYTE_W-1:0]    wr_byte_data,
    output logic                 wr_commit,
    output logic                 sr_wr_valid,
    output logic [BYTE_W-1:0]    sr_wr_data
);
    logic                 sck_rise;
    logic                 sck_fall;
    logic                 cs_rise;
    eng_state_e           state;
    logic [BIT_CNT_W-1:0] cnt;
    logic                 wel;
    logic [AW-1:0]        ptr;
    logic [BYTE_W-1:0]    status_byte;
    logic [BYTE_W-1:0]    load_byte;
    logic                 out_phase;

    spi_mem_edges u_edges (
        .clk      (clk),
        .rst      (rst),
        .sck      (sck),
        .cs_n     (cs_n),
        .hold_n   (hold_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise)
    );

    spi_mem_cmd #(.AW(AW), .PAGE_W(PAGE_W)) u_cmd (
        .clk           (clk),
        .rst           (rst),
        .cs_n          (cs_n),
        .si            (si),
        .sck_rise      (sck_rise),
        .cs_rise       (cs_rise),
        .busy          (busy),
        .wr_done       (wr_done),
        .state         (state),
        .cnt           (cnt),
        .wel           (wel),
        .ptr           (ptr),
        .wr_byte_valid (wr_byte_valid),
        .wr_byte_addr  (wr_byte_addr),
        .wr_byte_data  (wr_byte_data),
        .wr_commit     (wr_commit),
        .sr_wr_valid   (sr_wr_valid),
        .sr_wr_data    (sr_wr_data)
    );

    assign status_byte = {stat_hi, wel, busy};
    assign out_phase   = is_out_state(state);
    assign load_byte   = (state == ST_RD) ? mem_rdata : status_byte;
    assign mem_addr    = ptr;
    assign so_oe       = !cs_n && hold_n && out_phase;

    spi_mem_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .sck_fall  (sck_fall),
        .out_phase (out_phase),
        .load      (cnt == '0),
        .load_byte (load_byte),
        .so        (so)
    );
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          sck,
    input logic          cs_n,
    input logic          hold_n,
    input logic          so,
    input logic          so_oe,
    input logic          wr_commit,
    input logic          wr_byte_valid,
    input logic          sr_wr_valid,
    input logic [AW-1:0] mem_addr
);
    logic sck_d;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck;
    end

    p_oe_off_r14: assert property (@(posedge clk) disable iff (rst)
        (cs_n || !hold_n) |-> !so_oe);

    p_hold_freeze_r11: assert property (@(posedge clk) disable iff (rst)
        (!hold_n && !cs_n) |=> ($stable(mem_addr) && $stable(so)));

    p_so_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (so != $past(so)) |-> ($past(!sck) && $past(sck_d) && $past(!cs_n)));

    p_commit_after_cs_r8: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> ($past(cs_n) && !wr_byte_valid));

    p_commit_single_r8: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> !wr_commit);

    p_byte_single_r7: assert property (@(posedge clk) disable iff (rst)
        wr_byte_valid |=> !wr_byte_valid);

    p_srwr_after_cs_r13: assert property (@(posedge clk) disable iff (rst)
        sr_wr_valid |-> $past(cs_n));
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic        hold_n = 1'b1;
    logic        so;
    logic        so_oe;
    logic [12:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        busy = 1'b0;
    logic        wr_done = 1'b0;
    logic [5:0]  stat_hi = 6'b101101;
    logic        wr_byte_valid;
    logic [12:0] wr_byte_addr;
    logic [7:0]  wr_byte_data;
    logic        wr_commit;
    logic        sr_wr_valid;
    logic [7:0]  sr_wr_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [12:0] wb_addr_q[$];
    logic [7:0]  wb_data_q[$];
    int          commits = 0;
    int          sr_count = 0;
    logic [7:0]  sr_last = 8'h00;
    int          oe_high = 0;
    int          oe_bad = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(logic [12:0] a);
        return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5C;
    endfunction

    assign mem_rdata = pat(mem_addr);

    spi_mem_slave dut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .wr_done(wr_done), .stat_hi(stat_hi),
        .wr_byte_valid(wr_byte_valid), .wr_byte_addr(wr_byte_addr),
        .wr_byte_data(wr_byte_data), .wr_commit(wr_commit),
        .sr_wr_valid(sr_wr_valid), .sr_wr_data(sr_wr_data)
    );

    // per-cycle monitor and enable-rule model (R14)
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_byte_valid) begin
                wb_addr_q.push_back(wr_byte_addr);
                wb_data_q.push_back(wr_byte_data);
            end
            if (wr_commit) commits++;
            if (sr_wr_valid) begin
                sr_count++;
                sr_last = sr_wr_data;
            end
            if (so_oe) oe_high++;
            if (so_oe && (cs_n || !hold_n)) oe_bad++;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pause_here();
        hold_n = 1'b0;
        tick(2);
        sck = 1'b1; tick(3);
        sck = 1'b0; tick(3);
        hold_n = 1'b1;
        tick(2);
    endtask

    task automatic xb(input logic [7:0] tx, output logic [7:0] rx, input int hold_bit);
        for (int i = 7; i >= 0; i--) begin
            si = tx[i];
            tick(2);
            if (i == hold_bit) pause_here();
            rx[i] = so;
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
            tick(2);
        end
    endtask

    task automatic bits(input logic [7:0] tx, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            si = tx[i];
            tick(2);
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
            tick(2);
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        tick(2);
    endtask

    task automatic cs_hi();
        cs_n = 1'b1;
        tick(4);
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r;
        xb(b, r, -1);
    endtask

    task automatic rd_status(output logic [7:0] s);
        cs_lo();
        send(8'h05);
        xb(8'h00, s, -1);
        cs_hi();
    endtask

    task automatic one_cmd(input logic [7:0] op);
        cs_lo();
        send(op);
        cs_hi();
    endtask

    task automatic pulse_done();
        wr_done = 1'b1;
        tick(1);
        wr_done = 1'b0;
        tick(1);
    endtask

    initial begin
        logic [7:0] r;
        logic [7:0] s2;
        logic [12:0] a;
        tick(4);
        rst = 1'b0;
        tick(2);

        // reset state
        check("R14 reset so_oe", so_oe, 0);
        check("R7 reset wr_byte_valid", wr_byte_valid, 0);
        check("R8 reset wr_commit", wr_commit, 0);

        // R9 initial status: stat_hi=101101, latch 0, busy 0
        rd_status(r);
        check("R9 initial status", r, 8'hB4);

        // R1 R2: top address bits ignored, sequential read
        cs_lo();
        send(8'h03); send(8'hE0); send(8'h05);
        for (int k = 0; k < 3; k++) begin
            xb(8'h00, r, -1);
            check("R2 read at 0xE005 offset", r, pat(13'(5 + k)));
        end
        cs_hi();

        // R3 wrap from 0x1FFF to 0x0000
        cs_lo();
        send(8'h03); send(8'h1F); send(8'hFE);
        a = 13'h1FFE;
        for (int k = 0; k < 4; k++) begin
            xb(8'h00, r, -1);
            check("R3 sequential read with wrap", r, pat(a));
            a = a + 1'b1;
        end
        cs_hi();

        // R6 write without latch
        cs_lo();
        send(8'h02); send(8'h00); send(8'h10); send(8'h11); send(8'h22);
        cs_hi();
        check("R6 no byte strobes without latch", wb_addr_q.size(), 0);
        check("R6 no commit without latch", commits, 0);

        // R4 extra clocks after latch command cancel it
        cs_lo();
        send(8'h06); send(8'h02);
        cs_hi();
        rd_status(r);
        check("R4 latch not set after extra bits", r[1], 0);

        // R4 proper latch set; R9 status repeats within one select
        one_cmd(8'h06);
        cs_lo();
        send(8'h05);
        xb(8'h00, r, -1);
        xb(8'h00, s2, -1);
        cs_hi();
        check("R4 latch set", r, 8'hB6);
        check("R9 status repeats", s2, 8'hB6);

        // R7 R8 page write with in-page wrap
        cs_lo();
        send(8'h02); send(8'h00); send(8'h3E);
        send(8'hAA); send(8'hBB); send(8'hCC);
        cs_hi();
        check("R7 byte count", wb_addr_q.size(), 3);
        if (wb_addr_q.size() == 3) begin
            check("R7 addr0", wb_addr_q[0], 13'h003E);
            check("R7 addr1", wb_addr_q[1], 13'h003F);
            check("R7 addr2 page wrap", wb_addr_q[2], 13'h0020);
            check("R7 data0", wb_data_q[0], 8'hAA);
            check("R7 data2", wb_data_q[2], 8'hCC);
        end
        check("R8 commit after whole bytes", commits, 1);

        // R5 drop command clears latch
        one_cmd(8'h04);
        rd_status(r);
        check("R5 latch cleared by drop command", r[1], 0);

        // R8 partial byte: no commit
        one_cmd(8'h06);
        wb_addr_q.delete();
        wb_data_q.delete();
        cs_lo();
        send(8'h02); send(8'h01); send(8'h00);
        send(8'h77);
        bits(8'hFF, 3);
        cs_hi();
        check("R8 partial byte count", wb_addr_q.size(), 1);
        check("R8 no commit on partial byte", commits, 1);

        // R5 wr_done clears latch
        rd_status(r);
        check("R5 latch still set before done", r[1], 1);
        pulse_done();
        rd_status(r);
        check("R5 latch cleared by wr_done", r[1], 0);

        // R10 read refused while busy; R9 status served while busy
        busy = 1'b1;
        tick(2);
        oe_high = 0;
        cs_lo();
        send(8'h03); send(8'h00); send(8'h10);
        send(8'h00); send(8'h00);
        cs_hi();
        check("R10 no output while busy", oe_high, 0);
        rd_status(r);
        check("R9 status while busy", r, 8'hB5);
        busy = 1'b0;
        tick(2);

        // R13 status write with latch; R6 without latch
        one_cmd(8'h06);
        cs_lo();
        send(8'h01); send(8'h5A);
        cs_hi();
        check("R13 status write count", sr_count, 1);
        check("R13 status write data", sr_last, 8'h5A);
        pulse_done();
        cs_lo();
        send(8'h01); send(8'hA5);
        cs_hi();
        check("R6 status write refused without latch", sr_count, 1);

        // R11 pause during address and data
        cs_lo();
        send(8'h03);
        send(8'h00);
        xb(8'h40, r, 3);
        xb(8'h00, r, 5);
        check("R11 data after pauses", r, pat(13'h0040));
        xb(8'h00, r, -1);
        check("R11 next byte after pauses", r, pat(13'h0041));
        cs_hi();

        // R12 unknown opcode ignored; select rise mid-byte resets
        oe_high = 0;
        cs_lo();
        send(8'hFF); send(8'h03); send(8'h00); send(8'h00); send(8'h00);
        cs_hi();
        check("R12 unknown opcode no output", oe_high, 0);
        cs_lo();
        bits(8'h03, 4);
        cs_hi();
        cs_lo();
        send(8'h03); send(8'h00); send(8'h02);
        xb(8'h00, r, -1);
        cs_hi();
        check("R12 R1 read after aborted byte", r, pat(13'h0002));

        check("R14 enable rule every cycle", oe_bad, 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule